// File: doc/BRIEF.md
# Ring-Buffer Segment Extractor

This block sits beside a circular receive buffer of `BUF_LEN` entries that an external writer fills. It produces no data itself. Its output is descriptors that tell a consumer which stretch of the buffer is new since the consumer last looked. Three event inputs can ask for a pass: half-fill, full-fill and line-idle. Any one of them, or several together, starts one service. On that service the block samples the writer's current index and compares it with the last-read index it keeps.

If the index has not moved, nothing is emitted. If it has moved forward, one (start, length) descriptor covers the gap. If it has wrapped, the new data is split into two linear pieces. The tail piece runs from the last-read index to the end of the buffer. The head piece runs from entry 0 up to the current index, and it is dropped when the current index is 0.

Descriptors leave over a valid/ready handshake. When the last descriptor of a service is accepted, the stored index takes the sampled value. Events that arrive while descriptors are still waiting are folded into one pending request. That request runs afterwards with a newly sampled index.

Top module: `ring_seg_extract`

## Requirements
- R1: After reset `seg_valid_o` is low and the stored last-read index is 0, so the first service with current index k > 0 emits the descriptor (start 0, length k).
- R2: A service whose sampled index equals the stored last-read index emits no descriptor.
- R3: A service whose sampled index c is greater than the stored index r emits exactly one descriptor (start r, length c−r).
- R4: A service with c < r emits (start r, length BUF_LEN−r) and then (start 0, length c), in that order.
- R5: A service with c < r and c = 0 emits only (start r, length BUF_LEN−r).
- R6: Once the last descriptor of a service has been accepted, the stored last-read index equals the sampled index c.
- R7: While `seg_valid_o` is high and `seg_ready_i` is low, `seg_valid_o`, `seg_start_o` and `seg_len_o` hold their values.
- R8: Any number of events seen while descriptors are pending cause exactly one further service. That service samples `wr_idx_i` in the first cycle after the final accept.
- R9: An event seen at a clock edge while the block is idle samples `wr_idx_i` at that edge. Any resulting descriptor is valid right after that edge.
- R10: The three event inputs are interchangeable, and events raised together at one edge cause a single service.
- R11: Every emitted descriptor has a nonzero length and start + length ≤ BUF_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_evt_i | input | 1 | Half-fill event pulse |
| full_evt_i | input | 1 | Full-fill event pulse |
| idle_evt_i | input | 1 | Line-idle event pulse |
| wr_idx_i | input | IDX_W | Writer's current index, 0..BUF_LEN−1 |
| seg_valid_o | output | 1 | Descriptor valid |
| seg_ready_i | input | 1 | Consumer accepts descriptor |
| seg_start_o | output | IDX_W | Descriptor start index |
| seg_len_o | output | LEN_W | Descriptor length in entries |

## Verification
The bench builds the block with BUF_LEN = 20. Because 20 is not a power of two, the tail length BUF_LEN−r cannot come out right through a masking shortcut. The index pattern 10, 15, 4, 12, 0 drives forward, wrapped and wrap-to-zero cases. Stalled handshakes check stability between the tail and head pieces, and a burst of events during a stall must collapse into a single service that uses a later index.

// File: rtl/ring_seg_pkg.sv
package ring_seg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    SPAN_NONE   = 2'd0,
    SPAN_LINEAR = 2'd1,
    SPAN_WRAP   = 2'd2
  } span_e;

endpackage

// File: rtl/ring_seg_trig.sv
module ring_seg_trig #(
  parameter int NUM_SRC = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               busy_i,
  output logic               req_o
);

  logic [NUM_SRC:0] any_chain;
  logic             any_evt;
  logic             pend_q;

  assign any_chain[0] = 1'b0;
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_or
    assign any_chain[g+1] = any_chain[g] | evt_i[g];
  end
  assign any_evt = any_chain[NUM_SRC];

  // fold events seen while busy into one request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (busy_i) pend_q <= pend_q | any_evt;
    else             pend_q <= 1'b0;
  end

  assign req_o = !busy_i && (any_evt || pend_q);

endmodule

// File: rtl/ring_seg_calc.sv
module ring_seg_calc
  import ring_seg_pkg::*;
#(
  parameter int BUF_LEN = 20,
  parameter int IDX_W   = $clog2(BUF_LEN),
  parameter int LEN_W   = $clog2(BUF_LEN + 1)
) (
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [IDX_W-1:0] cur_idx_i,
  output span_e            span_o,
  output logic [LEN_W-1:0] first_len_o,
  output logic             second_vld_o
);

  logic [LEN_W-1:0] rd_ext;
  logic [LEN_W-1:0] cur_ext;

  assign rd_ext  = LEN_W'(rd_idx_i);
  assign cur_ext = LEN_W'(cur_idx_i);

  always_comb begin
    span_o      = SPAN_NONE;
    first_len_o = '0;
    if (cur_idx_i > rd_idx_i) begin
      span_o      = SPAN_LINEAR;
      first_len_o = cur_ext - rd_ext;
    end else if (cur_idx_i < rd_idx_i) begin
      span_o      = SPAN_WRAP;
      first_len_o = LEN_W'(BUF_LEN) - rd_ext;
    end
  end

  assign second_vld_o = (span_o == SPAN_WRAP) && (cur_idx_i != '0);

endmodule

// File: rtl/ring_seg_seq.sv
module ring_seg_seq
  import ring_seg_pkg::*;
#(
  parameter int BUF_LEN = 20,
  parameter int IDX_W   = $clog2(BUF_LEN),
  parameter int LEN_W   = $clog2(BUF_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [IDX_W-1:0] cur_idx_i,
  input  span_e            span_i,
  input  logic [LEN_W-1:0] first_len_i,
  input  logic             second_vld_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             busy_o,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [IDX_W-1:0] start_o,
  output logic [LEN_W-1:0] len_o
);

  seq_state_e       state_q;
  logic [IDX_W-1:0] rd_q;
  logic [IDX_W-1:0] cur_q;
  logic [LEN_W-1:0] first_len_q;
  logic             second_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rd_q        <= '0;
      cur_q       <= '0;
      first_len_q <= '0;
      second_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_i && span_i != SPAN_NONE) begin
            cur_q       <= cur_idx_i;
            first_len_q <= first_len_i;
            second_q    <= second_vld_i;
            state_q     <= ST_FIRST;
          end
        end
        ST_FIRST: begin
          if (ready_i) begin
            if (second_q) begin
              state_q <= ST_SECOND;
            end else begin
              rd_q    <= cur_q;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_SECOND: begin
          if (ready_i) begin
            rd_q    <= cur_q;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_idx_o = rd_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign valid_o  = busy_o;
  assign start_o  = (state_q == ST_SECOND) ? '0 : rd_q;
  assign len_o    = (state_q == ST_SECOND) ? LEN_W'(cur_q) : first_len_q;

endmodule

// File: rtl/ring_seg_extract.sv
module ring_seg_extract
  import ring_seg_pkg::*;
#(
  parameter int BUF_LEN = 20,
  parameter int IDX_W   = $clog2(BUF_LEN),
  parameter int LEN_W   = $clog2(BUF_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             half_evt_i,
  input  logic             full_evt_i,
  input  logic             idle_evt_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  output logic             seg_valid_o,
  input  logic             seg_ready_i,
  output logic [IDX_W-1:0] seg_start_o,
  output logic [LEN_W-1:0] seg_len_o
);

  localparam int NUM_SRC = 3;

  logic             req;
  logic             busy;
  logic [IDX_W-1:0] rd_idx;
  span_e            span;
  logic [LEN_W-1:0] first_len;
  logic             second_vld;

  ring_seg_trig #(.NUM_SRC(NUM_SRC)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  ({idle_evt_i, full_evt_i, half_evt_i}),
    .busy_i (busy),
    .req_o  (req)
  );

  ring_seg_calc #(.BUF_LEN(BUF_LEN), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_calc (
    .rd_idx_i     (rd_idx),
    .cur_idx_i    (wr_idx_i),
    .span_o       (span),
    .first_len_o  (first_len),
    .second_vld_o (second_vld)
  );

  ring_seg_seq #(.BUF_LEN(BUF_LEN), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req),
    .cur_idx_i    (wr_idx_i),
    .span_i       (span),
    .first_len_i  (first_len),
    .second_vld_i (second_vld),
    .rd_idx_o     (rd_idx),
    .busy_o       (busy),
    .valid_o      (seg_valid_o),
    .ready_i      (seg_ready_i),
    .start_o      (seg_start_o),
    .len_o        (seg_len_o)
  );

endmodule

// File: rtl/ring_seg_chk.sv
module ring_seg_chk #(
  parameter int BUF_LEN = 20,
  parameter int IDX_W   = $clog2(BUF_LEN),
  parameter int LEN_W   = $clog2(BUF_LEN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             seg_valid_o,
  input logic             seg_ready_i,
  input logic [IDX_W-1:0] seg_start_o,
  input logic [LEN_W-1:0] seg_len_o
);

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      rst_quiet_chk: assert (!seg_valid_o);
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o && !seg_ready_i |=> seg_valid_o && $stable(seg_start_o) && $stable(seg_len_o));

  // R11
  len_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o |-> seg_len_o != '0);

  // R11
  in_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o |-> (int'(seg_start_o) + int'(seg_len_o)) <= BUF_LEN);

  // R4
  head_follows_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o && seg_ready_i && (int'(seg_start_o) + int'(seg_len_o) == BUF_LEN) && seg_start_o != '0
    |=> !seg_valid_o || seg_start_o == '0);

endmodule

bind ring_seg_extract ring_seg_chk #(.BUF_LEN(BUF_LEN), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .seg_valid_o (seg_valid_o),
  .seg_ready_i (seg_ready_i),
  .seg_start_o (seg_start_o),
  .seg_len_o   (seg_len_o)
);

// File: tb/tb_ring_seg_extract.sv
module tb_ring_seg_extract;

  localparam int N     = 20;
  localparam int IDX_W = $clog2(N);
  localparam int LEN_W = $clog2(N + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             half_evt = 1'b0, full_evt = 1'b0, idle_evt = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic             seg_valid;
  logic             seg_ready = 1'b0;
  logic [IDX_W-1:0] seg_start;
  logic [LEN_W-1:0] seg_len;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int got_n;
  int got_s [4];
  int got_l [4];

  always #4 clk = ~clk;

  ring_seg_extract #(.BUF_LEN(N)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .half_evt_i(half_evt), .full_evt_i(full_evt), .idle_evt_i(idle_evt),
    .wr_idx_i(wr_idx),
    .seg_valid_o(seg_valid), .seg_ready_i(seg_ready),
    .seg_start_o(seg_start), .seg_len_o(seg_len)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // src bits: [0] half, [1] full, [2] idle
  task automatic pulse(input logic [2:0] src, input int idx);
    wr_idx   = IDX_W'(idx);
    half_evt = src[0];
    full_evt = src[1];
    idle_evt = src[2];
    @(posedge clk);
    @(negedge clk);
    half_evt = 1'b0;
    full_evt = 1'b0;
    idle_evt = 1'b0;
  endtask

  task automatic run_window(input int cyc);
    seg_ready = 1'b1;
    got_n = 0;
    for (int i = 0; i < cyc; i++) begin
      if (seg_valid) begin
        if (got_n < 4) begin
          got_s[got_n] = int'(seg_start);
          got_l[got_n] = int'(seg_len);
        end
        got_n++;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 valid low after reset", int'(seg_valid), 0);
  endtask

  task automatic t_first_linear;
    pulse(3'b001, 10);
    chk("R9 valid right after event", int'(seg_valid), 1);
    run_window(6);
    chk("R1 count", got_n, 1);
    chk("R1 start from reset index", got_s[0], 0);
    chk("R3 len", got_l[0], 10);
  endtask

  task automatic t_no_move;
    pulse(3'b010, 10);
    run_window(6);
    chk("R2 no descriptor when unchanged", got_n, 0);
  endtask

  task automatic t_forward;
    pulse(3'b100, 15);
    run_window(6);
    chk("R3 count", got_n, 1);
    chk("R6 start is previous index", got_s[0], 10);
    chk("R3 len", got_l[0], 5);
  endtask

  task automatic t_wrap;
    pulse(3'b010, 4);
    run_window(8);
    chk("R4 count", got_n, 2);
    chk("R4 tail start", got_s[0], 15);
    chk("R4 tail len", got_l[0], 5);
    chk("R4 head start", got_s[1], 0);
    chk("R4 head len", got_l[1], 4);
  endtask

  task automatic t_wrap_zero;
    pulse(3'b001, 12);
    run_window(6);
    chk("R6 count", got_n, 1);
    chk("R6 start", got_s[0], 4);
    pulse(3'b100, 0);
    run_window(8);
    chk("R5 count", got_n, 1);
    chk("R5 start", got_s[0], 12);
    chk("R5 len", got_l[0], 8);
  endtask

  task automatic t_merge;
    seg_ready = 1'b0;
    pulse(3'b001, 6);
    chk("R3 start", int'(seg_start), 0);
    chk("R3 len", int'(seg_len), 6);
    pulse(3'b100, 9);
    chk("R7 valid held", int'(seg_valid), 1);
    chk("R7 len held", int'(seg_len), 6);
    pulse(3'b001, 11);
    wr_idx = IDX_W'(14);
    run_window(10);
    chk("R8 count", got_n, 2);
    chk("R8 first len", got_l[0], 6);
    chk("R8 pending start", got_s[1], 6);
    chk("R8 fresh index len", got_l[1], 8);
  endtask

  task automatic t_together;
    pulse(3'b111, 17);
    run_window(8);
    chk("R10 single service", got_n, 1);
    chk("R10 start", got_s[0], 14);
    chk("R10 len", got_l[0], 3);
  endtask

  task automatic t_wrap_stall;
    seg_ready = 1'b0;
    pulse(3'b010, 2);
    chk("R4 tail start", int'(seg_start), 17);
    chk("R4 tail len", int'(seg_len), 3);
    @(negedge clk);
    @(negedge clk);
    chk("R7 tail start held", int'(seg_start), 17);
    chk("R7 tail len held", int'(seg_len), 3);
    seg_ready = 1'b1;
    @(negedge clk);
    seg_ready = 1'b0;
    chk("R4 head valid", int'(seg_valid), 1);
    chk("R4 head start", int'(seg_start), 0);
    chk("R4 head len", int'(seg_len), 2);
    @(negedge clk);
    chk("R7 head len held", int'(seg_len), 2);
    run_window(4);
    chk("R4 head accepted once", got_n, 1);
    pulse(3'b100, 2);
    run_window(6);
    chk("R6 stored index is 2", got_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_linear();
    t_no_move();
    t_forward();
    t_wrap();
    t_wrap_zero();
    t_merge();
    t_together();
    t_wrap_stall();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule